// File: doc/BRIEF.md
# Programmable Multi-Output Video Timing Generator

The block produces the raster timing for a display pipeline. A pixel counter runs from 0 to one less than the programmed line length. A line counter runs from 1 to the number of lines in a field, and the field length is written in half-lines. After every field a field flag alternates between top and bottom. From this raster position the block derives four independent sync outputs and an active-video window flag. Each sync output has its own horizontal pulse and its own vertical pulse, and the top and bottom fields are programmed separately. The current pixel, line and field are also driven out for downstream pixel logic.

Software configures the block over a simple write bus with a combinational read port. The bus can restart the raster and can select free-running operation or operation locked to an external sync. An interrupt unit records a top-field event and a bottom-field event. Status bits are cleared by writing ones. The mask is changed through separate set and clear addresses, so no read-modify-write is needed.

Top module: `vtg_timing_gen`

## Requirements
- R1: After reset the position is pixel 0, line 1, top field (field_bot_o = 0), and irq_o is 0. On each clock the pixel advances by one. When pixel+1 reaches the line length (address 0x01, bits 15:0), the pixel returns to 0 and the line advances.
- R2: The lines per field are the field length (address 0x02, bits 15:0, in half-lines) shifted right by one. After the line that is greater than or equal to this count, the line returns to 1 and field_bot_o toggles.
- R3: A write to address 0x03 with bit 0 set puts the position at pixel 0, line 1, top field on the next clock. A write there with bit 0 clear has no effect.
- R4: Each output k has an hsync word at 0x10+8k: start in bits 15:0, stop in bits 31:16. hsync_o[k] is high for start <= pixel < stop. When start > stop the pulse wraps across the end of the line (pixel >= start or pixel < stop). When start = stop the pulse never asserts.
- R5: Output k has top-field words at 0x11+8k (line pair) and 0x13+8k (sample pair), and bottom-field words at 0x12+8k and 0x14+8k. The rise point is (line pair low half, sample pair low half) and the fall point is the two high halves. vsync_o[k] is high from the rise point, inclusive, to the fall point, exclusive. Points are ordered by line first, then pixel. When rise > fall the pulse wraps across the end of the frame.
- R6: active_o is high when the line and the pixel both lie inclusively between a start word and a stop word. Each word holds line << 16 | pixel. The top field uses 0x04/0x05 and the bottom field uses 0x06/0x07.
- R7: Status bit 1 (top) or bit 0 (bottom) sets on the clock after the position is pixel 0, line 1 of that field. Writing ones to 0x09 clears the corresponding bits, and a set in the same cycle wins. The status reads at 0x08.
- R8: Writing ones to 0x0A sets mask bits and writing ones to 0x0B clears them. The mask reads at 0x0A. irq_o is high when any status bit is set together with its mask bit.
- R9: Bit 0 of address 0x00 selects slave mode (1) or master mode (0). In slave mode, ext_sync high at a clock edge realigns the position to pixel 0, line 1, top field. In master mode ext_sync is ignored.
- R10: The configuration of each output affects only its own hsync_o and vsync_o bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for status and mask addresses, otherwise 0 |
| ext_sync | input | 1 | External realignment pulse used in slave mode |
| hsync_o | output | 4 | Horizontal sync, one bit per output |
| vsync_o | output | 4 | Vertical sync, one bit per output |
| active_o | output | 1 | Active-video window flag |
| field_bot_o | output | 1 | 1 while the bottom field runs |
| hpos_o | output | 16 | Current pixel number |
| vline_o | output | 16 | Current line number, from 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench programs a 10-pixel, 6-line raster and sweeps every position over several fields. It checks all four outputs against expected values that it computes by arithmetic. The sweep includes an hsync window that wraps across the line end, a window with start equal to stop, and a vsync pulse that starts on the last line and ends in the next frame. A comparison without wrap handling would leave these pulses dark or stuck on. Top and bottom field settings differ, so a design that ignored the field flag would show the wrong pulse on every other field. A restart written with bit 0 clear, and external syncs sent in master mode, must leave the raster untouched. A design that realigns on either would shift every later position. The interrupt checks clear the status while events arrive and remove one mask bit, so a request from the wrong field or a stale status is detected.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int unsigned HW = 16;

    typedef logic [HW-1:0] half_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } pair_t;

    typedef struct packed {
        pair_t hwin;
        pair_t vl_top;
        pair_t vl_bot;
        pair_t vo_top;
        pair_t vo_bot;
    } sync_cfg_t;

    localparam int A_MODE     = 'h00;
    localparam int A_LINE_LEN = 'h01;
    localparam int A_HALF_LN  = 'h02;
    localparam int A_RESTART  = 'h03;
    localparam int A_WTOP_S   = 'h04;
    localparam int A_WTOP_E   = 'h05;
    localparam int A_WBOT_S   = 'h06;
    localparam int A_WBOT_E   = 'h07;
    localparam int A_STAT     = 'h08;
    localparam int A_STAT_CLR = 'h09;
    localparam int A_MASK_SET = 'h0A;
    localparam int A_MASK_CLR = 'h0B;
    localparam int OUT_BASE   = 'h10;
    localparam int OUT_STRIDE = 8;

    // inclusive low bound, exclusive high bound, wrapping when lo > hi
    function automatic logic span_hit(input logic [2*HW-1:0] k,
                                      input logic [2*HW-1:0] lo,
                                      input logic [2*HW-1:0] hi);
        if (lo <= hi) return (k >= lo) && (k < hi);
        return (k >= lo) || (k < hi);
    endfunction

endpackage

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  half_t line_len,
    input  half_t half_lines,
    input  logic  realign,
    output half_t hpos,
    output half_t vline,
    output logic  field_bot
);

    typedef struct packed {
        half_t h;
        half_t v;
        logic  f;
    } cnt_t;

    localparam cnt_t CNT_HOME = '{h: '0, v: half_t'(1), f: 1'b0};

    cnt_t          cnt_d, cnt_q;
    half_t         n_lines;
    logic [HW:0]   h_inc;

    always_comb begin
        n_lines = half_lines >> 1;
        h_inc   = {1'b0, cnt_q.h} + 1'b1;
        cnt_d   = cnt_q;
        if (realign) begin
            cnt_d = CNT_HOME;
        end else if (h_inc >= {1'b0, line_len}) begin
            cnt_d.h = '0;
            if (cnt_q.v >= n_lines) begin
                cnt_d.v = half_t'(1);
                cnt_d.f = ~cnt_q.f;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = h_inc[HW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_HOME;
        else        cnt_q <= cnt_d;
    end

    assign hpos      = cnt_q.h;
    assign vline     = cnt_q.v;
    assign field_bot = cnt_q.f;

endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
    import vtg_pkg::*;
(
    input  half_t     hpos,
    input  half_t     vline,
    input  logic      field_bot,
    input  sync_cfg_t cfg,
    output logic      hsync,
    output logic      vsync
);

    pair_t vl, vo;

    always_comb begin
        vl    = field_bot ? cfg.vl_bot : cfg.vl_top;
        vo    = field_bot ? cfg.vo_bot : cfg.vo_top;
        hsync = span_hit({half_t'(0), hpos}, {half_t'(0), cfg.hwin.lo}, {half_t'(0), cfg.hwin.hi});
        vsync = span_hit({vline, hpos}, {vl.lo, vo.lo}, {vl.hi, vo.hi});
    end

endmodule

// File: rtl/vtg_irq.sv
module vtg_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] event_in,
    input  logic [1:0] stat_clr,
    input  logic [1:0] mask_set,
    input  logic [1:0] mask_clr,
    output logic [1:0] status,
    output logic [1:0] mask,
    output logic       irq
);

    typedef struct packed {
        logic [1:0] stat;
        logic [1:0] mask;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.stat = (irq_q.stat & ~stat_clr) | event_in;
        irq_d.mask = (irq_q.mask | mask_set) & ~mask_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign status = irq_q.stat;
    assign mask   = irq_q.mask;
    assign irq    = |(irq_q.stat & irq_q.mask);

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ext_sync,
    output logic [NUM_OUT-1:0] hsync_o,
    output logic [NUM_OUT-1:0] vsync_o,
    output logic               active_o,
    output logic               field_bot_o,
    output logic [HW-1:0]      hpos_o,
    output logic [HW-1:0]      vline_o,
    output logic               irq_o
);

    typedef struct packed {
        logic                        slave;
        half_t                       line_len;
        half_t                       half_lines;
        pair_t                       wtop_s;
        pair_t                       wtop_e;
        pair_t                       wbot_s;
        pair_t                       wbot_e;
        sync_cfg_t [NUM_OUT-1:0]     outs;
    } cfg_t;

    cfg_t       cfg_d, cfg_q;
    logic       restart;
    logic       realign;
    logic [1:0] stat_clr, mask_set, mask_clr, ev;
    logic [1:0] status, mask;
    half_t      hpos, vline;
    logic       field_bot;
    pair_t      win_s, win_e;
    int         a;

    always_comb begin
        cfg_d    = cfg_q;
        restart  = 1'b0;
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        a        = 32'(bus_addr);
        if (bus_we) begin
            case (a)
                A_MODE:     cfg_d.slave      = bus_wdata[0];
                A_LINE_LEN: cfg_d.line_len   = bus_wdata[HW-1:0];
                A_HALF_LN:  cfg_d.half_lines = bus_wdata[HW-1:0];
                A_RESTART:  restart          = bus_wdata[0];
                A_WTOP_S:   cfg_d.wtop_s     = bus_wdata;
                A_WTOP_E:   cfg_d.wtop_e     = bus_wdata;
                A_WBOT_S:   cfg_d.wbot_s     = bus_wdata;
                A_WBOT_E:   cfg_d.wbot_e     = bus_wdata;
                A_STAT_CLR: stat_clr         = bus_wdata[1:0];
                A_MASK_SET: mask_set         = bus_wdata[1:0];
                A_MASK_CLR: mask_clr         = bus_wdata[1:0];
                default: ;
            endcase
            for (int k = 0; k < int'(NUM_OUT); k++) begin
                if (a == OUT_BASE + OUT_STRIDE*k + 0) cfg_d.outs[k].hwin   = bus_wdata;
                if (a == OUT_BASE + OUT_STRIDE*k + 1) cfg_d.outs[k].vl_top = bus_wdata;
                if (a == OUT_BASE + OUT_STRIDE*k + 2) cfg_d.outs[k].vl_bot = bus_wdata;
                if (a == OUT_BASE + OUT_STRIDE*k + 3) cfg_d.outs[k].vo_top = bus_wdata;
                if (a == OUT_BASE + OUT_STRIDE*k + 4) cfg_d.outs[k].vo_bot = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign realign = restart | (cfg_q.slave & ext_sync);

    vtg_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_len   (cfg_q.line_len),
        .half_lines (cfg_q.half_lines),
        .realign    (realign),
        .hpos       (hpos),
        .vline      (vline),
        .field_bot  (field_bot)
    );

    for (genvar k = 0; k < int'(NUM_OUT); k++) begin : g_out
        vtg_sync_out u_out (
            .hpos      (hpos),
            .vline     (vline),
            .field_bot (field_bot),
            .cfg       (cfg_q.outs[k]),
            .hsync     (hsync_o[k]),
            .vsync     (vsync_o[k])
        );
    end

    always_comb begin
        win_s    = field_bot ? cfg_q.wbot_s : cfg_q.wtop_s;
        win_e    = field_bot ? cfg_q.wbot_e : cfg_q.wtop_e;
        active_o = (vline >= win_s.hi) && (vline <= win_e.hi) &&
                   (hpos  >= win_s.lo) && (hpos  <= win_e.lo);
        ev       = '0;
        if (hpos == '0 && vline == half_t'(1)) begin
            ev = field_bot ? 2'b01 : 2'b10;
        end
    end

    vtg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (ev),
        .stat_clr (stat_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .status   (status),
        .mask     (mask),
        .irq      (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (32'(bus_addr) == A_STAT)          bus_rdata[1:0] = status;
        else if (32'(bus_addr) == A_MASK_SET) bus_rdata[1:0] = mask;
    end

    assign hpos_o      = hpos;
    assign vline_o     = vline;
    assign field_bot_o = field_bot;

endmodule

// File: rtl/vtg_timing_gen_chk.sv
module vtg_timing_gen_chk
    import vtg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       slave,
    input logic       ext_sync,
    input half_t      hpos,
    input half_t      vline,
    input logic       field_bot,
    input logic [1:0] status
);

    // R1
    hpos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hpos == '0) || (hpos == $past(hpos) + 1'b1));

    // R2
    field_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_bot) |-> (hpos == '0) && (vline == half_t'(1)));

    // R3
    restart_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (hpos == '0) && (vline == half_t'(1)) && !field_bot);

    // R9
    slave_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && ext_sync) |=> (hpos == '0) && (vline == half_t'(1)) && !field_bot);

    // R7
    top_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past((hpos == '0) && (vline == half_t'(1)) && !field_bot));

    // R7
    bot_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past((hpos == '0) && (vline == half_t'(1)) && field_bot));

endmodule

bind vtg_timing_gen vtg_timing_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .slave     (cfg_q.slave),
    .ext_sync  (ext_sync),
    .hpos      (hpos),
    .vline     (vline),
    .field_bot (field_bot),
    .status    (status)
);

// File: tb/vtg_timing_gen_tb.sv
module vtg_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_sync = 1'b0;
    logic [3:0]  hsync_o, vsync_o;
    logic        active_o, field_bot_o, irq_o;
    logic [15:0] hpos_o, vline_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vtg_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sync(ext_sync),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .active_o(active_o),
        .field_bot_o(field_bot_o), .hpos_o(hpos_o), .vline_o(vline_o), .irq_o(irq_o)
    );

    // bench model of the raster and registers
    longint m_h = 0, m_v = 1;
    int     m_f = 0;
    int     m_stat = 0, m_mask = 0, c_slave = 0;
    longint c_len = 0, c_half = 0;
    longint c_win [4];
    longint c_hw [4], c_vlt [4], c_vlb [4], c_vot [4], c_vob [4];

    function automatic bit span(longint k, longint lo, longint hi);
        if (lo <= hi) return (k >= lo) && (k < hi);
        return (k >= lo) || (k < hi);
    endfunction

    function automatic longint lo16(longint w); return w % 65536; endfunction
    function automatic longint hi16(longint w); return (w / 65536) % 65536; endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [3:0] e_hs, e_vs;
        bit e_act;
        longint ws, we_;
        for (int k = 0; k < 4; k++) begin
            longint vl = m_f ? c_vlb[k] : c_vlt[k];
            longint vo = m_f ? c_vob[k] : c_vot[k];
            e_hs[k] = span(m_h, lo16(c_hw[k]), hi16(c_hw[k]));
            e_vs[k] = span(m_v*65536 + m_h, lo16(vl)*65536 + lo16(vo), hi16(vl)*65536 + hi16(vo));
        end
        ws = m_f ? c_win[2] : c_win[0];
        we_ = m_f ? c_win[3] : c_win[1];
        e_act = (m_v >= hi16(ws)) && (m_v <= hi16(we_)) && (m_h >= lo16(ws)) && (m_h <= lo16(we_));
        chk(hpos_o == 16'(m_h), "R1 pixel position", hpos_o, m_h);
        chk(vline_o == 16'(m_v), "R2 line position", vline_o, m_v);
        chk(field_bot_o == m_f[0], "R2 field flag", field_bot_o, m_f);
        chk(hsync_o == e_hs, "R4 R10 hsync", hsync_o, e_hs);
        chk(vsync_o == e_vs, "R5 R10 vsync", vsync_o, e_vs);
        chk(active_o == e_act, "R6 active window", active_o, e_act);
        chk(irq_o == ((m_stat & m_mask) != 0), "R8 irq", irq_o, (m_stat & m_mask) != 0);
    endtask

    task automatic step_model();
        int  ev = 0;
        bit  realign;
        longint nl = lo16(c_half) / 2;
        int  a = int'(bus_addr);
        if (m_h == 0 && m_v == 1) ev = m_f ? 1 : 2;
        realign = (bus_we && a == 3 && bus_wdata[0]) || (c_slave == 1 && ext_sync);
        if (realign) begin
            m_h = 0; m_v = 1; m_f = 0;
        end else if (m_h + 1 >= c_len) begin
            m_h = 0;
            if (m_v >= nl) begin m_v = 1; m_f = 1 - m_f; end
            else m_v = m_v + 1;
        end else begin
            m_h = m_h + 1;
        end
        if (bus_we) begin
            if (a == 9) m_stat = m_stat & ~int'(bus_wdata[1:0]);
            if (a == 10) m_mask = m_mask | int'(bus_wdata[1:0]);
            if (a == 11) m_mask = m_mask & ~int'(bus_wdata[1:0]);
            if (a == 0) c_slave = int'(bus_wdata[0]);
            if (a == 1) c_len = lo16(bus_wdata);
            if (a == 2) c_half = lo16(bus_wdata);
            if (a >= 4 && a <= 7) c_win[a-4] = bus_wdata;
            for (int k = 0; k < 4; k++) begin
                if (a == 16 + 8*k) c_hw[k] = bus_wdata;
                if (a == 17 + 8*k) c_vlt[k] = bus_wdata;
                if (a == 18 + 8*k) c_vlb[k] = bus_wdata;
                if (a == 19 + 8*k) c_vot[k] = bus_wdata;
                if (a == 20 + 8*k) c_vob[k] = bus_wdata;
            end
        end
        m_stat = m_stat | ev;
    endtask

    task automatic cyc();
        check_outputs();
        step_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input longint data);
        bus_we = 1'b1; bus_addr = 8'(addr); bus_wdata = 32'(data);
        cyc();
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic read_back();
        bus_addr = 8'h08; #1;
        chk(bus_rdata == 32'(m_stat), "R7 status readback", bus_rdata, m_stat);
        bus_addr = 8'h0A; #1;
        chk(bus_rdata == 32'(m_mask), "R8 mask readback", bus_rdata, m_mask);
        bus_addr = 8'h00;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            c_win[k] = 0; c_hw[k] = 0; c_vlt[k] = 0; c_vlb[k] = 0; c_vot[k] = 0; c_vob[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(hpos_o == 0 && vline_o == 1 && field_bot_o == 0, "R1 reset position",
            {hpos_o, vline_o}, 32'h0000_0001);
        chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
        read_back();

        wr('h01, 10);
        wr('h02, 12);
        wr('h04, (2 << 16) | 1);
        wr('h05, (5 << 16) | 7);
        wr('h06, (3 << 16) | 0);
        wr('h07, (4 << 16) | 9);
        // output 0: plain windows, fields differ
        wr('h10, (5 << 16) | 2);
        wr('h11, (2 << 16) | 1);
        wr('h13, (3 << 16) | 3);
        wr('h12, (4 << 16) | 3);
        wr('h14, (8 << 16) | 0);
        // output 1: wrapping hsync and vsync across frame end
        wr('h18, (2 << 16) | 8);
        wr('h19, (1 << 16) | 6);
        wr('h1B, (4 << 16) | 7);
        wr('h1A, (1 << 16) | 6);
        wr('h1C, (4 << 16) | 7);
        // output 2: empty windows on top, wrapping vsync on bottom
        wr('h20, (4 << 16) | 4);
        wr('h21, (3 << 16) | 3);
        wr('h23, (5 << 16) | 5);
        wr('h22, (2 << 16) | 5);
        wr('h24, (0 << 16) | 9);
        // output 3
        wr('h28, (9 << 16) | 0);
        wr('h29, (5 << 16) | 2);
        wr('h2B, 0);
        wr('h2A, (6 << 16) | 1);
        wr('h2C, (9 << 16) | 0);

        wr('h09, 3);
        wr('h0A, 3);
        read_back();
        // R3 restart
        wr('h03, 1);
        chk(hpos_o == 0 && vline_o == 1 && field_bot_o == 0, "R3 restart home",
            {hpos_o, vline_o}, 32'h0000_0001);
        for (int rep = 0; rep < 8; rep++) begin
            run(29);
            read_back();
            wr('h09, 3);
        end
        // R8 drop top mask
        wr('h0B, 2);
        read_back();
        for (int rep = 0; rep < 4; rep++) begin
            run(29);
            read_back();
            wr('h09, rep % 2 + 1);
        end
        // R3 restart with bit 0 clear is ignored
        run(13);
        wr('h03, 2);
        run(20);
        // R9 master mode ignores ext_sync
        ext_sync = 1'b1;
        cyc();
        ext_sync = 1'b0;
        chk(!(hpos_o == 0 && vline_o == 1), "R9 master ignores ext_sync", hpos_o, 0);
        run(20);
        wr('h00, 1);
        run(17);
        ext_sync = 1'b1;
        cyc();
        ext_sync = 1'b0;
        chk(hpos_o == 0 && vline_o == 1 && field_bot_o == 0, "R9 slave realign",
            {hpos_o, vline_o}, 32'h0000_0001);
        run(130);
        read_back();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule